// File: doc/BRIEF.md
# Guarded Watermark Update Unit

This block keeps the arbitration thresholds that a memory-request arbiter reads: four sets, each with five fields. The fields are urgency, trip-to-memory latency, self-refresh entry, self-refresh exit and memory-clock change. Software presents one request at a time. A request names a set, a field, a time in nanoseconds, the current reference clock in MHz and a safe-to-lower qualifier. The block turns the time into reference-clock cycles, saturates the result, and decides whether to commit it.

Raising a threshold always takes effect. Lowering one takes effect only while the safe qualifier is high. A lowering that is refused leaves the old value in place and marks the field as pending. The pending marks are collected into three groups and one overall flag, so that software knows it must retry once lowering becomes safe. The comparison uses the stored nanosecond request rather than the cycle count, so saturation cannot hide a raise. Each committed value is driven twice, once for data requests and once for address-translation row requests. A registered readback port returns the committed cycle counts.

Top module: `wmk_update_unit`

## Requirements
- R1: After reset, every stored value and cycle count is zero, no pending mark is set, and `done`, `upd_pend` and `pend_any` are low.
- R2: A committed request stores cycles equal to floor(ns × MHz / 1000).
- R3: A converted count above 2^CYC_W−1 is stored as 2^CYC_W−1.
- R4: A request strictly greater than the stored nanosecond value commits whatever the safe qualifier, even when the old and new counts both saturate.
- R5: While `safe_lower` is high, any request commits, including a lowering, and clears that field's pending mark.
- R6: While `safe_lower` is low, a request strictly below the stored value is not written; `upd_pend` is high with `done` and the field's pending mark is set.
- R7: While `safe_lower` is low, a request equal to the stored value writes nothing, raises no `upd_pend` and clears the field's pending mark.
- R8: An update changes only the addressed field of the addressed set.
- R9: The data-request and row-request copies of every threshold (`thr_data`/`thr_row`, `rd_data`/`rd_row`) always hold the same value. Entry e = set×5 + field occupies bits [e×CYC_W +: CYC_W].
- R10: `grp_pend` bit 0 is the OR of the pending marks of fields 0 (urgency) and 1 (trip latency) across all sets. Bit 1 covers fields 2 and 3 (self-refresh entry and exit), and bit 2 covers field 4 (memory-clock change). `pend_any` is the OR of the three bits.
- R11: `done` is high for exactly the one cycle after a valid `ld_stb`, and the new state is visible in that same cycle. `upd_pend` is never high without `done`.
- R12: A strobe whose field code is 5, 6 or 7 is ignored: there is no `done` and no change of state.
- R13: `rd_data` returns the committed count of (`rd_set`, `rd_fld`) one cycle after the address is presented. A field code of 5 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Request strobe |
| ld_set | input | $clog2(SETS) | Target set |
| ld_fld | input | 3 | Target field code 0..4 |
| ld_ns | input | NS_W | Requested time in ns |
| refclk_mhz | input | MHZ_W | Reference clock in MHz |
| safe_lower | input | 1 | Lowering allowed |
| done | output | 1 | Update finished (one cycle) |
| upd_pend | output | 1 | That update was a refused lowering |
| grp_pend | output | 3 | Pending per group |
| pend_any | output | 1 | OR of group pending |
| rd_set | input | $clog2(SETS) | Readback set |
| rd_fld | input | 3 | Readback field code |
| rd_data | output | CYC_W | Readback, data copy |
| rd_row | output | CYC_W | Readback, row copy |
| thr_data | output | SETS×5×CYC_W | All thresholds, data copy |
| thr_row | output | SETS×5×CYC_W | All thresholds, row copy |

## Verification
The bench builds the block with SETS=4, NS_W=16, MHZ_W=10 and CYC_W=12. With a 12-bit count, a request of a few thousand nanoseconds at a high clock rate already saturates. This lets the bench reach the clamp and the case where a raise hides behind saturation with small operands. A 16-bit nanosecond field keeps equal requests frequent in the random phase, which exercises the no-write, no-pending path together with the invalid field codes.

// File: rtl/wmk_pkg.sv
package wmk_pkg;
  localparam int NUM_FLD = 5;
  localparam int NUM_GRP = 3;
  localparam int FLD_W   = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_URG    = 3'd0,
    FLD_TRIP   = 3'd1,
    FLD_SR_IN  = 3'd2,
    FLD_SR_OUT = 3'd3,
    FLD_MCLK   = 3'd4
  } wmk_fld_e;

  // group index for a field: 0 urgency, 1 self-refresh, 2 clock change
  function automatic int grp_of(input int f);
    case (f)
      int'(FLD_URG), int'(FLD_TRIP):     return 0;
      int'(FLD_SR_IN), int'(FLD_SR_OUT): return 1;
      default:                           return 2;
    endcase
  endfunction
endpackage

// File: rtl/wmk_convert.sv
module wmk_convert #(
  parameter int NS_W  = 24,
  parameter int MHZ_W = 10,
  parameter int CYC_W = 21
) (
  input  logic [NS_W-1:0]  ns,
  input  logic [MHZ_W-1:0] mhz,
  output logic [CYC_W-1:0] cyc
);
  localparam int PW = NS_W + MHZ_W;
  localparam int WW = PW + CYC_W;

  logic [PW-1:0] prod;
  logic [PW-1:0] quo;
  logic [WW-1:0] quo_w;
  logic [WW-1:0] max_w;

  always_comb begin
    prod  = PW'(ns) * PW'(mhz);
    quo   = prod / PW'(1000);
    quo_w = WW'(quo);
    max_w = {{PW{1'b0}}, {CYC_W{1'b1}}};
    if (quo_w > max_w) cyc = {CYC_W{1'b1}};
    else               cyc = quo_w[CYC_W-1:0];
  end
endmodule

// File: rtl/wmk_guard.sv
module wmk_guard #(
  parameter int NS_W = 24
) (
  input  logic [NS_W-1:0] req_ns,
  input  logic [NS_W-1:0] cur_ns,
  input  logic            safe,
  output logic            commit,
  output logic            refused
);
  always_comb begin
    commit  = safe || (req_ns > cur_ns);
    refused = !safe && (req_ns < cur_ns);
  end
endmodule

// File: rtl/wmk_store.sv
module wmk_store #(
  parameter int ENTRIES = 20,
  parameter int NS_W    = 24,
  parameter int CYC_W   = 21,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [NS_W-1:0]          wr_ns,
  input  logic [CYC_W-1:0]         wr_cyc,
  input  logic                     pb_en,
  input  logic                     pb_val,
  output logic [NS_W-1:0]          cur_ns,
  input  logic                     rd_ok,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [CYC_W-1:0]         rd_cyc,
  output logic [CYC_W-1:0]         rd_cyc_row,
  output logic [ENTRIES*CYC_W-1:0] cyc_flat,
  output logic [ENTRIES*CYC_W-1:0] row_flat,
  output logic [ENTRIES-1:0]       pend_vec
);
  logic [NS_W-1:0]  ns_q  [ENTRIES];
  logic [CYC_W-1:0] cyc_q [ENTRIES];
  logic [CYC_W-1:0] row_q [ENTRIES];
  logic [ENTRIES-1:0] pb_q;

  always_comb begin
    if (int'(wr_idx) < ENTRIES) cur_ns = ns_q[wr_idx];
    else                        cur_ns = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ns_q[i]  <= '0;
        cyc_q[i] <= '0;
        row_q[i] <= '0;
      end
      pb_q       <= '0;
      rd_cyc     <= '0;
      rd_cyc_row <= '0;
    end else begin
      if (wr_en) begin
        ns_q[wr_idx]  <= wr_ns;
        cyc_q[wr_idx] <= wr_cyc;
        row_q[wr_idx] <= wr_cyc;
      end
      if (pb_en) pb_q[wr_idx] <= pb_val;
      if (rd_ok) begin
        rd_cyc     <= cyc_q[rd_idx];
        rd_cyc_row <= row_q[rd_idx];
      end else begin
        rd_cyc     <= '0;
        rd_cyc_row <= '0;
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_flat
    assign cyc_flat[e*CYC_W +: CYC_W] = cyc_q[e];
    assign row_flat[e*CYC_W +: CYC_W] = row_q[e];
  end

  assign pend_vec = pb_q;
endmodule

// File: rtl/wmk_update_unit.sv
module wmk_update_unit
  import wmk_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int NS_W  = 24,
  parameter int MHZ_W = 10,
  parameter int CYC_W = 21,
  localparam int SET_W   = $clog2(SETS),
  localparam int ENTRIES = SETS * NUM_FLD,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int THR_W   = ENTRIES * CYC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_stb,
  input  logic [SET_W-1:0]   ld_set,
  input  logic [FLD_W-1:0]   ld_fld,
  input  logic [NS_W-1:0]    ld_ns,
  input  logic [MHZ_W-1:0]   refclk_mhz,
  input  logic               safe_lower,
  output logic               done,
  output logic               upd_pend,
  output logic [NUM_GRP-1:0] grp_pend,
  output logic               pend_any,
  input  logic [SET_W-1:0]   rd_set,
  input  logic [FLD_W-1:0]   rd_fld,
  output logic [CYC_W-1:0]   rd_data,
  output logic [CYC_W-1:0]   rd_row,
  output logic [THR_W-1:0]   thr_data,
  output logic [THR_W-1:0]   thr_row
);
  logic             ld_ok, go, rd_ok;
  logic [IDX_W-1:0] ld_idx, rd_idx;
  logic [NS_W-1:0]  cur_ns;
  logic [CYC_W-1:0] new_cyc;
  logic             commit, refused;
  logic [ENTRIES-1:0] pend_vec;

  always_comb begin
    ld_ok  = (int'(ld_fld) < NUM_FLD) && (int'(ld_set) < SETS);
    rd_ok  = (int'(rd_fld) < NUM_FLD) && (int'(rd_set) < SETS);
    go     = ld_stb && ld_ok;
    ld_idx = IDX_W'(ld_set) * IDX_W'(NUM_FLD) + IDX_W'(ld_fld);
    rd_idx = IDX_W'(rd_set) * IDX_W'(NUM_FLD) + IDX_W'(rd_fld);
  end

  wmk_convert #(.NS_W(NS_W), .MHZ_W(MHZ_W), .CYC_W(CYC_W)) conv_i (
    .ns(ld_ns), .mhz(refclk_mhz), .cyc(new_cyc)
  );

  wmk_guard #(.NS_W(NS_W)) guard_i (
    .req_ns(ld_ns), .cur_ns(cur_ns), .safe(safe_lower),
    .commit(commit), .refused(refused)
  );

  wmk_store #(.ENTRIES(ENTRIES), .NS_W(NS_W), .CYC_W(CYC_W), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst),
    .wr_en(go && commit), .wr_idx(ld_idx), .wr_ns(ld_ns), .wr_cyc(new_cyc),
    .pb_en(go), .pb_val(refused), .cur_ns(cur_ns),
    .rd_ok(rd_ok), .rd_idx(rd_idx), .rd_cyc(rd_data), .rd_cyc_row(rd_row),
    .cyc_flat(thr_data), .row_flat(thr_row), .pend_vec(pend_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      upd_pend <= 1'b0;
    end else begin
      done     <= go;
      upd_pend <= go && refused;
    end
  end

  always_comb begin
    grp_pend = '0;
    for (int s = 0; s < SETS; s++)
      for (int f = 0; f < NUM_FLD; f++)
        grp_pend[grp_of(f)] = grp_pend[grp_of(f)] | pend_vec[s*NUM_FLD+f];
    pend_any = |grp_pend;
  end
endmodule

// File: rtl/wmk_update_unit_chk.sv
module wmk_update_unit_chk
  import wmk_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int CYC_W = 21,
  localparam int SET_W = $clog2(SETS),
  localparam int THR_W = SETS * NUM_FLD * CYC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_stb,
  input logic [SET_W-1:0] ld_set,
  input logic [FLD_W-1:0] ld_fld,
  input logic             safe_lower,
  input logic             done,
  input logic             upd_pend,
  input logic             pend_any,
  input logic [THR_W-1:0] thr_data
);
  logic valid_ld;
  assign valid_ld = ld_stb && (int'(ld_fld) < NUM_FLD) && (int'(ld_set) < SETS);

  // R11
  done_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    valid_ld |=> done);
  // R12
  no_done_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_ld |=> !done);
  // R11
  pend_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pend |-> done);
  // R6
  pend_only_unsafe_chk: assert property (@(posedge clk) disable iff (rst)
    valid_ld && safe_lower |=> !upd_pend);
  // R10
  pend_aggregate_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pend |-> pend_any);
  // R8
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(thr_data));
endmodule

bind wmk_update_unit wmk_update_unit_chk #(.SETS(SETS), .CYC_W(CYC_W)) chk_i (
  .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_set(ld_set), .ld_fld(ld_fld),
  .safe_lower(safe_lower), .done(done), .upd_pend(upd_pend),
  .pend_any(pend_any), .thr_data(thr_data)
);

// File: tb/wmk_update_unit_tb.sv
module wmk_update_unit_tb_top;
  localparam int SETS = 4, NS_W = 16, MHZ_W = 10, CYC_W = 12;
  localparam int NF = 5;
  localparam int THR_W = SETS * NF * CYC_W;
  localparam int MAXC = (1 << CYC_W) - 1;

  logic clk = 0, rst = 1;
  logic ld_stb = 0, safe_lower = 0;
  logic [1:0] ld_set = 0, rd_set = 0;
  logic [2:0] ld_fld = 0, rd_fld = 0;
  logic [NS_W-1:0] ld_ns = 0;
  logic [MHZ_W-1:0] refclk_mhz = 0;
  logic done, upd_pend, pend_any;
  logic [2:0] grp_pend;
  logic [CYC_W-1:0] rd_data, rd_row;
  logic [THR_W-1:0] thr_data, thr_row;

  wmk_update_unit #(.SETS(SETS), .NS_W(NS_W), .MHZ_W(MHZ_W), .CYC_W(CYC_W)) dut_i (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_set(ld_set), .ld_fld(ld_fld),
    .ld_ns(ld_ns), .refclk_mhz(refclk_mhz), .safe_lower(safe_lower),
    .done(done), .upd_pend(upd_pend), .grp_pend(grp_pend), .pend_any(pend_any),
    .rd_set(rd_set), .rd_fld(rd_fld), .rd_data(rd_data), .rd_row(rd_row),
    .thr_data(thr_data), .thr_row(thr_row)
  );

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ns [SETS][NF];
  int m_cyc[SETS][NF];
  bit m_pb [SETS][NF];
  bit m_done, m_up;
  int m_rd;

  function automatic int conv(input int ns, input int mhz);
    longint p;
    p = (longint'(ns) * mhz) / 1000;
    if (p > MAXC) p = MAXC;
    return int'(p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_ns[s, f]) begin m_ns[s][f] = 0; m_cyc[s][f] = 0; m_pb[s][f] = 0; end
      m_done = 0; m_up = 0; m_rd = 0;
    end else begin
      m_rd = (rd_fld < NF) ? m_cyc[rd_set][rd_fld] : 0;
      m_done = 0; m_up = 0;
      if (ld_stb && ld_fld < NF) begin
        m_done = 1;
        if (safe_lower || int'(ld_ns) > m_ns[ld_set][ld_fld]) begin
          m_ns[ld_set][ld_fld]  = int'(ld_ns);
          m_cyc[ld_set][ld_fld] = conv(int'(ld_ns), int'(refclk_mhz));
          m_pb[ld_set][ld_fld]  = 0;
        end else if (int'(ld_ns) < m_ns[ld_set][ld_fld]) begin
          m_pb[ld_set][ld_fld] = 1;
          m_up = 1;
        end else m_pb[ld_set][ld_fld] = 0;
      end
    end
  end

  function automatic logic [2:0] m_grp();
    logic [2:0] g = 0;
    for (int s = 0; s < SETS; s++) begin
      g[0] |= m_pb[s][0] | m_pb[s][1];
      g[1] |= m_pb[s][2] | m_pb[s][3];
      g[2] |= m_pb[s][4];
    end
    return g;
  endfunction

  function automatic logic [THR_W-1:0] m_thr();
    logic [THR_W-1:0] v = 0;
    for (int s = 0; s < SETS; s++)
      for (int f = 0; f < NF; f++)
        v[(s*NF+f)*CYC_W +: CYC_W] = CYC_W'(m_cyc[s][f]);
    return v;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R11 done", done, m_done);
      chk("R6 upd_pend", upd_pend, m_up);
      chk("R10 grp_pend", grp_pend, m_grp());
      chk("R10 pend_any", pend_any, |m_grp());
      chk("R13 rd_data", rd_data, m_rd);
      chk("R9 rd_row", rd_row, m_rd);
      total++;
      if (thr_data !== m_thr()) begin fails++; $display("FAIL R2 thr_data actual=%h expected=%h", thr_data, m_thr()); end
      total++;
      if (thr_row !== m_thr()) begin fails++; $display("FAIL R9 thr_row actual=%h expected=%h", thr_row, m_thr()); end
    end
  end

  // one request; returns after the cycle in which done is shown
  task automatic upd(input int s, input int f, input int ns, input int mhz, input bit safe);
    @(negedge clk);
    ld_stb = 1; ld_set = 2'(s); ld_fld = 3'(f); ld_ns = NS_W'(ns);
    refclk_mhz = MHZ_W'(mhz); safe_lower = safe;
    @(negedge clk);
    ld_stb = 0;
  endtask

  task automatic rd(input int s, input int f, input int exp, input string tag);
    @(negedge clk);
    rd_set = 2'(s); rd_fld = 3'(f);
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 pend_any", pend_any, 0);
    chk("R1 thr", (thr_data == 0), 1);
    rd(2, 3, 0, "R1 rd_data");

    upd(0, 0, 1500, 100, 0);
    chk("R11 done", done, 1); chk("R4 upd_pend", upd_pend, 0);
    @(negedge clk); chk("R11 done one cycle", done, 0);
    rd(0, 0, 150, "R4 raise");
    upd(0, 0, 1234, 333, 1);
    rd(0, 0, 410, "R2 floor / R5 safe lowering");
    upd(0, 0, 1000, 333, 0);
    chk("R6 upd_pend", upd_pend, 1); chk("R10 grp", grp_pend, 3'b001);
    rd(0, 0, 410, "R6 no write");
    upd(0, 0, 1234, 500, 0);
    chk("R7 upd_pend", upd_pend, 0); chk("R7 grp cleared", grp_pend, 3'b000);
    rd(0, 0, 410, "R7 no write");
    upd(1, 2, 60000, 1000, 0);
    rd(1, 2, MAXC, "R3 clamp");
    upd(1, 2, 61000, 1000, 0);
    chk("R4 raise under clamp", upd_pend, 0);
    upd(1, 2, 60500, 1000, 0);
    chk("R6 lower under clamp", upd_pend, 1); chk("R10 grp sr", grp_pend, 3'b010);
    upd(2, 4, 100, 1000, 0);
    upd(2, 4, 50, 1000, 0);
    chk("R10 grp mclk", grp_pend, 3'b110); chk("R10 any", pend_any, 1);
    upd(3, 0, 2000, 100, 1);
    rd(3, 0, 200, "R8 set 3");
    rd(0, 0, 410, "R8 set 0 untouched");
    upd(0, 5, 9999, 100, 1);
    chk("R12 no done", done, 0); chk("R12 grp", grp_pend, 3'b110);
    rd(0, 0, 410, "R12 no write");
    rd(0, 6, 0, "R13 invalid read");
    upd(1, 2, 10, 1000, 1);
    chk("R5 clears pend", grp_pend, 3'b100);
    rd(1, 2, 10, "R5 commit");
    chk("R9 row copy", rd_row, 10);

    begin
      int unsigned r = 32'h1234_5678;
      for (int i = 0; i < 600; i++) begin
        r ^= r << 13; r ^= r >> 17; r ^= r << 5;
        rd_set = 2'(r >> 20); rd_fld = 3'((r >> 24) % 6);
        upd(int'(r % 4), int'((r >> 3) % 7), int'(((r >> 8) % 8) * 700 + ((r >> 30) * 20000)),
            int'(50 + (r >> 12) % 900), ((r >> 16) % 4) == 0);
      end
    end
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule